// File: doc/BRIEF.md
# FEAC Codeword Transmit Sequencer

This block produces the serial far-end alarm and control stream carried in one overhead bit of a DS3 frame. A host sets a 2-bit action select and two 6-bit codeword values, A and B. The block answers with one output bit in every cycle where the channel-bit strobe is high. That bit is either part of the all-ones idle fill or part of a 16-bit pattern built from one of the codewords. A real-time idle flag tells the host whether the bit on the line is idle fill or codeword content.

Actions are triggered by an edge. A move of the select from zero to a nonzero value starts an action, but only while the sequencer is idle. The two one-shot actions finish their full run without further help from the host. The continuous action repeats codeword A until the host writes the select back to zero. Even then it sends at least ten words, and it always stops at a word boundary.

The surrounding framer places the output bit into the frame and handles any interrupt latching.

Top module: `feac_tx_seq`

## Requirements
- R1: After reset, and whenever no action is running, every strobed bit slot carries tx_bit=1 with tx_idle=1.
- R2: A codeword is sent as 16 bits, in this order: a 0, the six codeword bits starting with bit 0, a 0, then eight 1s. tx_idle is 0 for all 16 bits.
- R3: Select value 01 sends codeword A ten times and then returns to idle fill.
- R4: Select value 10 sends codeword A ten times, then codeword B ten times, then returns to idle fill.
- R5: Select value 11 repeats codeword A. It stops at the end of a word, only after the select has been seen at 00 and only once at least ten words have gone out.
- R6: An action starts only when the select goes from 00 to a nonzero value while the block is idle. Such an edge is discarded if it arrives while a sequence is running. Holding a nonzero select never starts another action.
- R7: Actions 01 and 10 finish their complete sequence even if the select returns to 00 partway through.
- R8: The output advances by one bit only in cycles where bit_en is high. In all other cycles, tx_bit and tx_idle hold their values.
- R9: Asserting rst_n low forces tx_bit=1 and tx_idle=1 at once, even in the middle of a sequence, and leaves the block idle.
- R10: The first codeword bit appears on the first strobed cycle after the clock edge at which the starting edge of the select is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| act_sel | input | 2 | Action select: 00 idle, 01 A x10, 10 A x10 then B x10, 11 A continuous |
| cw_a | input | 6 | Codeword A |
| cw_b | input | 6 | Codeword B |
| bit_en | input | 1 | Channel-bit strobe; one output bit per high cycle |
| tx_bit | output | 1 | Serial output bit |
| tx_idle | output | 1 | High while the current output bit is idle fill |

## Verification
Two situations are the hardest to reach from the ports. One is cancelling the continuous action after its tenth word. The other is a select edge that lands while a one-shot action is running. For the first, the bench queues fourteen words and watches its own scoreboard drain. It writes the select to 00 only when eight bits of the fourteenth word remain. This places the stop request inside that word, so the expected end falls on a known boundary. For the second, the bench takes the select from 01 through 00 to 10 in the middle of a run. It then checks that only the first sequence appears and that the held 10 never starts anything afterwards.

// File: rtl/feac_pkg.sv
package feac_pkg;
  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_A10  = 2'b01,
    ACT_AB10 = 2'b10,
    ACT_CONT = 2'b11
  } feac_act_e;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'b00,
    SEQ_A    = 2'b01,
    SEQ_B    = 2'b10
  } feac_seq_e;
endpackage

// File: rtl/feac_sel_edge.sv
module feac_sel_edge #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel_i,
  output logic             start_o
);
  logic [SEL_W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sel_i;
  end

  assign start_o = (prev_q == '0) && (sel_i != '0);
endmodule

// File: rtl/feac_word_fmt.sv
module feac_word_fmt #(
  parameter int CW_W   = 6,
  parameter int WORD_W = 2 * (CW_W + 2)
) (
  input  logic [CW_W-1:0]   cw_i,
  output logic [WORD_W-1:0] word_o
);
  localparam int ONES_W = WORD_W - CW_W - 2;

  assign word_o[0]      = 1'b0;
  assign word_o[CW_W+1] = 1'b0;

  for (genvar g = 0; g < CW_W; g++) begin : g_cw
    assign word_o[g+1] = cw_i[g];
  end

  for (genvar k = 0; k < ONES_W; k++) begin : g_ones
    assign word_o[CW_W+2+k] = 1'b1;
  end
endmodule

// File: rtl/feac_rep_cnt.sv
module feac_rep_cnt #(
  parameter int REPS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int CNT_W = (REPS > 1) ? $clog2(REPS) : 1;
  localparam logic [CNT_W-1:0] MAXV = CNT_W'(REPS - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)                      cnt_d = '0;
    else if (inc_i && cnt_q != MAXV) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign last_o = (cnt_q == MAXV);
endmodule

// File: rtl/feac_tx_seq.sv
module feac_tx_seq
  import feac_pkg::*;
#(
  parameter int CW_W = 6,
  parameter int REPS = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      act_sel,
  input  logic [CW_W-1:0] cw_a,
  input  logic [CW_W-1:0] cw_b,
  input  logic            bit_en,
  output logic            tx_bit,
  output logic            tx_idle
);
  localparam int WORD_W = 2 * (CW_W + 2);
  localparam int IDX_W  = $clog2(WORD_W);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_W - 1);

  feac_seq_e        st_q, st_d;
  feac_act_e        mode_q, mode_d;
  logic             stop_q, stop_d;
  logic [IDX_W-1:0] bidx_q, bidx_d;
  logic             tx_q, tx_d;
  logic             idle_q, idle_d;
  logic             start, cnt_clr, cnt_inc, cnt_last;
  logic [WORD_W-1:0] word_a, word_b, cur_word;

  feac_sel_edge #(.SEL_W(2)) u_edge (
    .clk(clk), .rst_n(rst_n), .sel_i(act_sel), .start_o(start)
  );

  feac_word_fmt #(.CW_W(CW_W), .WORD_W(WORD_W)) u_fmt_a (
    .cw_i(cw_a), .word_o(word_a)
  );

  feac_word_fmt #(.CW_W(CW_W), .WORD_W(WORD_W)) u_fmt_b (
    .cw_i(cw_b), .word_o(word_b)
  );

  feac_rep_cnt #(.REPS(REPS)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr_i(cnt_clr), .inc_i(cnt_inc),
    .last_o(cnt_last)
  );

  assign cur_word = (st_q == SEQ_B) ? word_b : word_a;

  always_comb begin
    st_d    = st_q;
    mode_d  = mode_q;
    stop_d  = stop_q;
    bidx_d  = bidx_q;
    tx_d    = tx_q;
    idle_d  = idle_q;
    cnt_clr = 1'b0;
    cnt_inc = 1'b0;
    if (st_q == SEQ_IDLE) begin
      if (bit_en) begin
        tx_d   = 1'b1;
        idle_d = 1'b1;
      end
      if (start) begin
        st_d    = SEQ_A;
        mode_d  = feac_act_e'(act_sel);
        stop_d  = 1'b0;
        bidx_d  = '0;
        cnt_clr = 1'b1;
      end
    end else begin
      if (mode_q == ACT_CONT && act_sel == 2'b00) stop_d = 1'b1;
      if (bit_en) begin
        tx_d   = cur_word[bidx_q];
        idle_d = 1'b0;
        if (bidx_q == LAST_IDX) begin
          bidx_d  = '0;
          cnt_inc = 1'b1;
          if (cnt_last) begin
            unique case (mode_q)
              ACT_AB10: begin
                if (st_q == SEQ_A) begin
                  st_d    = SEQ_B;
                  cnt_clr = 1'b1;
                end else begin
                  st_d = SEQ_IDLE;
                end
              end
              ACT_CONT: if (stop_d) st_d = SEQ_IDLE;
              default:  st_d = SEQ_IDLE;
            endcase
          end
        end else begin
          bidx_d = bidx_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      mode_q <= ACT_NONE;
      stop_q <= 1'b0;
      bidx_q <= '0;
      tx_q   <= 1'b1;
      idle_q <= 1'b1;
    end else begin
      st_q   <= st_d;
      mode_q <= mode_d;
      stop_q <= stop_d;
      bidx_q <= bidx_d;
      tx_q   <= tx_d;
      idle_q <= idle_d;
    end
  end

  assign tx_bit  = tx_q;
  assign tx_idle = idle_q;
endmodule

// File: rtl/feac_tx_seq_chk.sv
module feac_tx_seq_chk
  import feac_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int LAST  = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       act_sel,
  input logic             bit_en,
  input logic             tx_bit,
  input logic             tx_idle,
  input feac_seq_e        st_q,
  input feac_act_e        mode_q,
  input logic [IDX_W-1:0] bidx_q,
  input logic             cnt_last
);
  logic word_end;
  assign word_end = bit_en && (bidx_q == IDX_W'(LAST));

  // R8
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> ($stable(tx_bit) && $stable(tx_idle)));

  // R2
  idle_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_idle |-> tx_bit);

  // R2
  lead_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != SEQ_IDLE && bit_en && bidx_q == '0) |=> (!tx_bit && !tx_idle));

  // R1
  idle_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SEQ_IDLE && bit_en) |=> (tx_bit && tx_idle));

  // R6
  zero_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SEQ_IDLE && act_sel == 2'b00) |=> (st_q == SEQ_IDLE));

  // R5
  min_reps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SEQ_A && mode_q == ACT_CONT && !(word_end && cnt_last))
      |=> (st_q == SEQ_A));

  // R7
  one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SEQ_A && mode_q == ACT_A10 && !(word_end && cnt_last))
      |=> (st_q == SEQ_A));
endmodule

bind feac_tx_seq feac_tx_seq_chk #(.IDX_W(IDX_W), .LAST(WORD_W - 1)) u_chk (
  .clk(clk), .rst_n(rst_n), .act_sel(act_sel), .bit_en(bit_en),
  .tx_bit(tx_bit), .tx_idle(tx_idle), .st_q(st_q), .mode_q(mode_q),
  .bidx_q(bidx_q), .cnt_last(cnt_last)
);

// File: tb/tb_feac_tx_seq.sv
module tb_feac_tx_seq;
  typedef struct {
    logic  b;
    logic  idl;
    string req;
  } exp_t;

  logic       clk, rst_n, bit_en, tx_bit, tx_idle;
  logic [1:0] act_sel;
  logic [5:0] cw_a, cw_b;

  exp_t q[$];
  int   checks, errors;
  bit   mon_on, full_rate, done;
  logic last_tx, last_idle;

  feac_tx_seq dut (
    .clk(clk), .rst_n(rst_n), .act_sel(act_sel), .cw_a(cw_a), .cw_b(cw_b),
    .bit_en(bit_en), .tx_bit(tx_bit), .tx_idle(tx_idle)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic ab,
                       input logic ai, input logic eb, input logic ei);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: tx_bit=%b tx_idle=%b expected tx_bit=%b tx_idle=%b",
               req, ab, ai, eb, ei);
    end
  endtask

  function automatic logic pat_bit(input logic [5:0] cw, input int i);
    if (i == 0 || i == 7) return 1'b0;
    if (i <= 6) return cw[i-1];
    return 1'b1;
  endfunction

  task automatic push_words(input logic [5:0] cw, input int n, input string req);
    for (int w = 0; w < n; w++)
      for (int i = 0; i < 16; i++) begin
        exp_t e;
        e.b = pat_bit(cw, i);
        e.idl = 1'b0;
        e.req = req;
        q.push_back(e);
      end
  endtask

  // select write at a falling edge; expectations queued after the sampling edge (R10)
  task automatic start_action(input logic [1:0] sel);
    @(negedge clk);
    act_sel = sel;
    @(posedge clk);
    #1;
  endtask

  task automatic idle_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain;
    while (q.size() != 0) @(negedge clk);
  endtask

  // strobe generator: every cycle or two of three
  initial begin
    int ph;
    ph = 0;
    bit_en = 1'b0;
    forever begin
      @(negedge clk);
      ph = (ph == 2) ? 0 : ph + 1;
      bit_en = full_rate ? 1'b1 : (ph != 2);
    end
  end

  // monitor / scoreboard
  initial begin
    logic en;
    bit   have;
    exp_t e;
    last_tx = 1'b1;
    last_idle = 1'b1;
    forever begin
      @(posedge clk);
      en = bit_en;
      have = (q.size() != 0);
      #2;
      if (mon_on && rst_n) begin
        if (en) begin
          if (have) begin
            e = q.pop_front();
            check(tx_bit === e.b && tx_idle === e.idl, e.req, tx_bit, tx_idle, e.b, e.idl);
          end else begin
            // R1 idle fill
            check(tx_bit === 1'b1 && tx_idle === 1'b1, "R1", tx_bit, tx_idle, 1'b1, 1'b1);
          end
        end else begin
          // R8 hold between strobes
          check(tx_bit === last_tx && tx_idle === last_idle, "R8",
                tx_bit, tx_idle, last_tx, last_idle);
        end
      end
      last_tx = tx_bit;
      last_idle = tx_idle;
    end
  end

  initial begin
    #(150000 * 10);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: tx_bit=%b tx_idle=%b expected sequence completion",
               tx_bit, tx_idle);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    checks = 0;
    errors = 0;
    done = 1'b0;
    mon_on = 1'b0;
    full_rate = 1'b1;
    act_sel = 2'b00;
    cw_a = 6'b101101;
    cw_b = 6'b010011;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(tx_bit === 1'b1 && tx_idle === 1'b1, "R1", tx_bit, tx_idle, 1'b1, 1'b1);
    rst_n = 1'b1;
    mon_on = 1'b1;
    idle_cycles(40);

    // R3 with R2 pattern, full-rate strobe
    start_action(2'b01);
    push_words(cw_a, 10, "R3");
    drain();
    idle_cycles(40);
    @(negedge clk) act_sel = 2'b00;
    idle_cycles(4);

    // R4, sparse strobe
    full_rate = 1'b0;
    start_action(2'b10);
    push_words(cw_a, 10, "R4");
    push_words(cw_b, 10, "R4");
    drain();
    @(negedge clk) act_sel = 2'b00;
    idle_cycles(30);

    // R7 completion despite 00; R6 edge during run discarded
    start_action(2'b01);
    push_words(cw_a, 10, "R7");
    idle_cycles(40);
    @(negedge clk) act_sel = 2'b00;
    idle_cycles(3);
    @(negedge clk) act_sel = 2'b10;
    drain();
    idle_cycles(80);   // held 10 must not start anything (R6)
    @(negedge clk) act_sel = 2'b11;  // nonzero to nonzero: no start (R6)
    idle_cycles(60);
    @(negedge clk) act_sel = 2'b00;
    idle_cycles(4);

    // R5 early cancel still yields ten words
    cw_a = 6'b000111;
    full_rate = 1'b1;
    start_action(2'b11);
    push_words(cw_a, 10, "R5");
    idle_cycles(20);
    @(negedge clk) act_sel = 2'b00;
    drain();
    idle_cycles(50);

    // R5 late cancel ends at the word in progress
    full_rate = 1'b0;
    start_action(2'b11);
    push_words(cw_a, 14, "R5");
    while (q.size() > 8) @(negedge clk);
    act_sel = 2'b00;
    drain();
    idle_cycles(60);

    // R9 reset in mid-sequence
    mon_on = 1'b0;
    start_action(2'b10);
    idle_cycles(30);
    @(negedge clk);
    act_sel = 2'b00;
    rst_n = 1'b0;
    #1;
    check(tx_bit === 1'b1 && tx_idle === 1'b1, "R9", tx_bit, tx_idle, 1'b1, 1'b1);
    idle_cycles(2);
    rst_n = 1'b1;
    mon_on = 1'b1;
    idle_cycles(60);   // must remain idle after reset (R9, R1)

    // restart after reset with new codeword (R3, R10)
    cw_a = 6'b110010;
    start_action(2'b01);
    push_words(cw_a, 10, "R3");
    drain();
    idle_cycles(30);

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule